// File: doc/BRIEF.md
# Bidirectional Timer Counter Unit

This block is the counting core of an 8-bit timer. An internal register holds the count. On each qualified timer tick the register is incremented, decremented or cleared, as the selected counting mode requires. A 3-bit select code chooses where the ticks come from:

- every system clock;
- one of four enable strobes from an outside prescaler;
- a rising or falling edge of an external pin, taken after that pin has been synchronized.

A select code of zero stops the count.

A 3-bit mode input chooses the counting sequence:

- a free-running up count;
- a count that clears after it matches compare value A;
- a triangle count that reverses at TOP and at BOTTOM.

TOP is either 0xFF or compare value A, depending on the mode. A bus-side write port can load the count at any time, whether or not ticks are present, and such a load overrides any tick in the same cycle. Two live flags report TOP and BOTTOM. A sticky overflow request is set on the wrap from MAX in the free-running mode and on arrival at zero in the triangle modes. It is cleared by a write-one strobe.

Top module: `tmr_updown_core`

## Requirements
- R1: After reset `cnt` is 0x00, `ovf_flag` is 0 and the counting direction is up; with `mode`=0, `at_bottom` is 1 and `at_top` is 0.
- R2: `clk_sel`=0 gives no ticks and the count holds. `clk_sel`=1 ticks on every clock. `clk_sel` codes 2, 3, 4 and 5 tick only in cycles where `pre_en[0]`, `pre_en[1]`, `pre_en[2]` or `pre_en[3]` respectively is high; the other enable bits are ignored.
- R3: `ext_in` passes through two synchronizing flip-flops and then an edge detector. Code 7 ticks on a rising edge and code 6 on a falling edge. A pin change applied between clock edges first shows in `cnt` after the third rising clock edge.
- R4: Mode 0 (free running, TOP=0xFF): each tick adds one, and 0xFF wraps to 0x00. That wrap sets `ovf_flag`.
- R5: Mode 2 (clear on match, TOP=`cmp_a`): a tick at `cnt`==`cmp_a` loads 0x00 and any other tick adds one, so a count above `cmp_a` runs on through 0xFF to 0x00. This mode never sets `ovf_flag`.
- R6: Mode 1 (triangle, TOP=0xFF) and mode 5 (triangle, TOP=`cmp_a`): the count rises to TOP, then falls to 0x00, then rises again. A tick that moves the count from a nonzero value to 0x00 sets `ovf_flag`. When TOP is 0x00 the count stays at 0x00.
- R7: Mode codes 3, 4, 6 and 7 behave exactly like mode 0.
- R8: A cycle with `cnt_we` high loads `cnt_wdata` into `cnt` at the next edge. This happens for any `clk_sel` and wins over a tick in the same cycle. In a triangle mode the load leaves the stored direction unchanged.
- R9: `at_top` is high whenever `cnt` equals the TOP of the present mode, and `at_bottom` is high whenever `cnt` is 0x00.
- R10: `ovf_flag` stays set until a cycle with `ovf_clr` high clears it. If a set condition and `ovf_clr` occur in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 3 | Tick source select code |
| pre_en | input | 4 | Prescaler enable strobes (divide by 8, 64, 256, 1024) |
| ext_in | input | 1 | Asynchronous external tick pin |
| mode | input | 3 | Counting mode code |
| cmp_a | input | 8 | Compare value A, used as TOP in modes 2 and 5 |
| cnt_we | input | 1 | Count write strobe |
| cnt_wdata | input | 8 | Value to load into the count |
| ovf_clr | input | 1 | Write-one clear of the overflow request |
| cnt | output | 8 | Present count |
| at_top | output | 1 | Count equals TOP |
| at_bottom | output | 1 | Count equals zero |
| ovf_flag | output | 1 | Sticky overflow request |

## Verification
Loads, internal ticks and overflow updates take effect at the first clock edge after the cycle in which they are presented. The TOP and BOTTOM flags follow the count combinationally. An external pin change takes three edges to reach the count: two for synchronization and one for the count update. The bench drives inputs on falling edges and reads results on the following falling edge, so each check falls between the edge that produced the result and the next one. For the external source, the bench samples at each of the three intermediate falling edges, which confirms that the count stays put until the third edge.

// File: rtl/tmr_updown_core.sv
module tmr_updown_core #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    clk_sel,
  input  logic [3:0]    pre_en,
  input  logic          ext_in,
  input  logic [2:0]    mode,
  input  logic [CW-1:0] cmp_a,
  input  logic          cnt_we,
  input  logic [CW-1:0] cnt_wdata,
  input  logic          ovf_clr,
  output logic [CW-1:0] cnt,
  output logic          at_top,
  output logic          at_bottom,
  output logic          ovf_flag
);
  localparam logic [CW-1:0] MAXV = '1;
  localparam logic [CW-1:0] BOTV = '0;
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic sy1, sy2, sy3;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {sy1, sy2, sy3} <= '0;
    else        {sy1, sy2, sy3} <= {ext_in, sy1, sy2};

  wire ext_rise = sy2 & ~sy3;
  wire ext_fall = ~sy2 & sy3;

  logic tick;
  always_comb
    case (clk_sel)
      3'd1:    tick = 1'b1;
      3'd2:    tick = pre_en[0];
      3'd3:    tick = pre_en[1];
      3'd4:    tick = pre_en[2];
      3'd5:    tick = pre_en[3];
      3'd6:    tick = ext_fall;
      3'd7:    tick = ext_rise;
      default: tick = 1'b0;
    endcase

  wire is_tri  = (mode == 3'd1) || (mode == 3'd5);
  wire is_ctc  = (mode == 3'd2);
  wire top_cmp = (mode == 3'd2) || (mode == 3'd5);
  wire [CW-1:0] top_val = top_cmp ? cmp_a : MAXV;

  logic          dir_dn;
  logic          go_dn;
  logic [CW-1:0] nxt;
  logic          ovf_set;

  always_comb begin
    go_dn   = dir_dn;
    nxt     = cnt + ONE;
    ovf_set = 1'b0;
    if (is_tri) begin
      if (cnt == top_val)   go_dn = 1'b1;
      else if (cnt == BOTV) go_dn = 1'b0;
      if (top_val == BOTV)  nxt = BOTV;
      else if (go_dn)       nxt = cnt - ONE;
      ovf_set = tick && (nxt == BOTV) && (cnt != BOTV);
    end else if (is_ctc) begin
      if (cnt == cmp_a) nxt = BOTV;
    end else begin
      ovf_set = tick && (cnt == MAXV);
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      cnt <= BOTV;
    else if (cnt_we) cnt <= cnt_wdata;
    else if (tick)   cnt <= nxt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 dir_dn <= 1'b0;
    else if (!is_tri)           dir_dn <= 1'b0;
    else if (tick && !cnt_we)   dir_dn <= go_dn;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                  ovf_flag <= 1'b0;
    else if (ovf_set && !cnt_we) ovf_flag <= 1'b1;
    else if (ovf_clr)            ovf_flag <= 1'b0;

  assign at_top    = (cnt == top_val);
  assign at_bottom = (cnt == BOTV);
endmodule

module tmr_updown_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    clk_sel,
  input logic [2:0]    mode,
  input logic [CW-1:0] cmp_a,
  input logic          cnt_we,
  input logic [CW-1:0] cnt_wdata,
  input logic          ovf_clr,
  input logic [CW-1:0] cnt,
  input logic          ovf_flag
);
  localparam logic [CW-1:0] MAXV = '1;

  p_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 3'd0 && !cnt_we) |=> $stable(cnt));

  p_wrap_ovf_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0 && clk_sel == 3'd1 && !cnt_we && cnt == MAXV) |=> (cnt == '0 && ovf_flag));

  p_match_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd2 && clk_sel == 3'd1 && !cnt_we && cnt == cmp_a) |=> (cnt == '0));

  p_turn_at_max_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd1 && clk_sel == 3'd1 && !cnt_we && cnt == MAXV) |=> (cnt == MAXV - 1'b1));

  p_write_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> (cnt == $past(cnt_wdata)));

  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);
endmodule

bind tmr_updown_core tmr_updown_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .mode(mode), .cmp_a(cmp_a),
  .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .ovf_clr(ovf_clr), .cnt(cnt),
  .ovf_flag(ovf_flag)
);

// File: tb/tmr_updown_core_tb.sv
module tmr_updown_core_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] clk_sel = '0;
  logic [3:0] pre_en = '0;
  logic       ext_in = 1'b0;
  logic [2:0] mode = '0;
  logic [7:0] cmp_a = '0;
  logic       cnt_we = 1'b0;
  logic [7:0] cnt_wdata = '0;
  logic       ovf_clr = 1'b0;
  logic [7:0] cnt;
  logic       at_top, at_bottom, ovf_flag;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  tmr_updown_core u_dut (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .pre_en(pre_en), .ext_in(ext_in),
    .mode(mode), .cmp_a(cmp_a), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
    .ovf_clr(ovf_clr), .cnt(cnt), .at_top(at_top), .at_bottom(at_bottom),
    .ovf_flag(ovf_flag)
  );

  // mode, cmp_a, preload, ticks, expected count, expected overflow
  localparam int NV = 11;
  localparam logic [35:0] VEC [NV] = '{
    {3'd0, 8'h00, 8'h10, 8'd5, 8'h15, 1'b0},   // R4
    {3'd0, 8'h00, 8'hFE, 8'd3, 8'h01, 1'b1},   // R4 wrap
    {3'd2, 8'h05, 8'h03, 8'd4, 8'h01, 1'b0},   // R5 match
    {3'd2, 8'h05, 8'hFE, 8'd3, 8'h01, 1'b0},   // R5 above compare
    {3'd1, 8'h00, 8'hFD, 8'd4, 8'hFD, 1'b0},   // R6 turn at 0xFF
    {3'd5, 8'h03, 8'h01, 8'd6, 8'h01, 1'b1},   // R6 turn at both ends
    {3'd5, 8'h03, 8'h00, 8'd3, 8'h03, 1'b0},   // R6 rise to compare
    {3'd3, 8'h00, 8'hFF, 8'd1, 8'h00, 1'b1},   // R7
    {3'd5, 8'h00, 8'h00, 8'd4, 8'h00, 1'b0},   // R6 TOP zero
    {3'd2, 8'h00, 8'h00, 8'd3, 8'h00, 1'b0},   // R5 compare zero
    {3'd7, 8'h00, 8'h7F, 8'd2, 8'h81, 1'b0}    // R7
  };

  task automatic chk(input string tag, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic load(input logic [7:0] v);
    cnt_we = 1'b1; cnt_wdata = v;
    @(negedge clk);
    cnt_we = 1'b0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_fail++;
        $display("FAIL watchdog: got %0d expected %0d", cyc, 100000);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    run(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 count", cnt, 0);
    chk("R1 ovf", ovf_flag, 0);
    chk("R1 bottom", at_bottom, 1);
    chk("R1 top", at_top, 0);

    for (int v = 0; v < NV; v++) begin
      mode = 3'd0; clk_sel = 3'd0; ovf_clr = 1'b1;
      load(VEC[v][24:17]);
      ovf_clr = 1'b0;
      mode = VEC[v][35:33]; cmp_a = VEC[v][32:25]; clk_sel = 3'd1;
      run(int'(VEC[v][16:9]));
      clk_sel = 3'd0;
      chk($sformatf("R4-7 vec%0d count", v), cnt, VEC[v][8:1]);
      chk($sformatf("R10 vec%0d ovf", v), ovf_flag, VEC[v][0]);
    end

    // R10 sticky and clear; vector 10 left ovf clear, make it set again
    mode = 3'd0; load(8'hFF);
    clk_sel = 3'd1; ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0; clk_sel = 3'd0;
    chk("R10 set beats clear", ovf_flag, 1);
    run(5);
    chk("R10 sticky", ovf_flag, 1);
    ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
    chk("R10 cleared", ovf_flag, 0);

    // R9 flags
    mode = 3'd0; load(8'hFF);
    chk("R9 top at max", at_top, 1);
    chk("R9 bottom off", at_bottom, 0);
    mode = 3'd2; cmp_a = 8'h20; load(8'h20);
    chk("R9 top at compare", at_top, 1);
    cmp_a = 8'h21; #0;
    chk("R9 top follows compare", at_top, 0);

    // R2 stopped and prescaler enables
    mode = 3'd0; load(8'h30);
    run(10);
    chk("R2 stopped", cnt, 8'h30);
    clk_sel = 3'd3; run(4);
    chk("R2 no enable", cnt, 8'h30);
    pre_en = 4'b0001; @(negedge clk); pre_en = '0;
    chk("R2 other enable ignored", cnt, 8'h30);
    pre_en = 4'b0010; @(negedge clk); pre_en = '0;
    chk("R2 enable 1 ticks", cnt, 8'h31);
    clk_sel = 3'd5; pre_en = 4'b1000; run(2); pre_en = '0;
    chk("R2 enable 3 ticks", cnt, 8'h33);
    clk_sel = 3'd2; pre_en = 4'b0001; run(1); pre_en = '0;
    chk("R2 enable 0 ticks", cnt, 8'h34);

    // R3 external edges
    clk_sel = 3'd7; run(3);
    ext_in = 1'b1;
    @(negedge clk); chk("R3 rise edge1", cnt, 8'h34);
    @(negedge clk); chk("R3 rise edge2", cnt, 8'h34);
    @(negedge clk); chk("R3 rise edge3", cnt, 8'h35);
    run(2); chk("R3 single tick", cnt, 8'h35);
    ext_in = 1'b0; run(4);
    chk("R3 fall ignored on rise code", cnt, 8'h35);
    clk_sel = 3'd6;
    ext_in = 1'b1; run(4);
    chk("R3 rise ignored on fall code", cnt, 8'h35);
    ext_in = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R3 fall edge2", cnt, 8'h35);
    @(negedge clk); chk("R3 fall edge3", cnt, 8'h36);
    clk_sel = 3'd0;

    // R8 write beats tick, and keeps triangle direction
    mode = 3'd0; clk_sel = 3'd1;
    load(8'h40);
    chk("R8 write over tick", cnt, 8'h40);
    @(negedge clk);
    chk("R8 tick after write", cnt, 8'h41);
    clk_sel = 3'd0; load(8'hFE);
    mode = 3'd1; clk_sel = 3'd1; run(2); clk_sel = 3'd0;
    chk("R6 turned down", cnt, 8'hFE);
    load(8'h50);
    clk_sel = 3'd1; @(negedge clk); clk_sel = 3'd0;
    chk("R8 direction kept", cnt, 8'h4F);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule